// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic array. An AND array outside the block produces up to eight product terms for the cell. The cell ORs them into a sum. It then passes that sum either through a D flip-flop or straight through as combinatorial logic, applies a selectable polarity, and decides whether the pin is driven. A separate enable bit stands beside the data bit, so a disabled pin reads as high impedance. A feedback bit returns the cell's state to the array.

Two global configuration bits are shared by every cell of the array. Together with one per-cell mode bit they select one of three operating styles:

- **Simple:** all terms are summed, and the pin is either always driven or always released.
- **Complex:** term 0 becomes a per-cell enable, and the other terms are summed.
- **Registered family:** the per-cell bit chooses between a registered cell, whose enable comes from a shared active-low pin, and a complex-style combinatorial cell.

A test preload path can force any value into the flip-flop. A synchronous start-up reset clears it.

Top module: `pal_macrocell`

## Requirements
- R1: With `glb_sync`=0 and `glb_tsel`=0 (simple style), `out_data` is the OR of all `N_TERMS` product terms, XORed with `loc_inv`, with no clock involved.
- R2: In the simple style, `out_en` is 1 when `cell_mode`=0 and 0 when `cell_mode`=1.
- R3: With `glb_sync`=0 and `glb_tsel`=1 (complex style), `out_en` equals `pterm[0]`, the sum uses only `pterm[N_TERMS-1:1]`, and `oe_pin_n` has no effect.
- R4: With `glb_sync`=1 and `cell_mode`=1 (registered), each rising clock edge stores the OR of `pterm[N_TERMS-1:1]` into the flip-flop, and `out_data` is the stored bit XOR `loc_inv`. `pterm[0]` does not take part.
- R5: In the registered cell, `out_en` equals the inverse of `oe_pin_n`.
- R6: With `glb_sync`=1 and `cell_mode`=0, the cell is combinatorial. `out_en` equals `pterm[0]` and the sum uses `pterm[N_TERMS-1:1]`.
- R7: `loc_inv`=1 inverts `out_data` in every style. The flip-flop always stores the true, non-inverted sum.
- R8: In the registered cell, `fb` is the stored bit. In the combinatorial styles, `fb` is the pin level: `out_data` when `out_en`=1, otherwise `pad_in`.
- R9: When `preload_en`=1 at a clock edge, the flip-flop takes `preload_val` instead of the sum.
- R10: When `rst_n`=0 at a clock edge, the flip-flop clears to 0, even if `preload_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output flip-flop |
| rst_n | input | 1 | Synchronous active-low start-up reset |
| pterm | input | N_TERMS | Product terms from the AND array |
| glb_sync | input | 1 | Global bit selecting the registered family |
| glb_tsel | input | 1 | Global bit selecting the complex style when `glb_sync`=0 |
| cell_mode | input | 1 | Per-cell mode bit |
| loc_inv | input | 1 | Per-cell polarity, 1 = active-low output |
| oe_pin_n | input | 1 | Shared active-low enable for registered cells |
| pad_in | input | 1 | Level seen on the pin when it is not driven |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value loaded by the preload |
| out_data | output | 1 | Data bit for the pin |
| out_en | output | 1 | Drive enable for the pin, 0 = high impedance |
| fb | output | 1 | Feedback bit to the array |

## Verification
Three writes can compete for the flip-flop in one cycle: the start-up reset, the test preload and the normal capture of the sum. The bench provokes these collisions directly. It loads a preload value that disagrees with the sum at the same edge. It then raises the preload during reset, with a value that disagrees with zero. After the edge, the bench reads the stored bit back through `fb` and `out_data` in the registered mode. The winner is judged against the priority order reset, then preload, then capture.

// File: rtl/pal_mc_pkg.sv
// Package: shared types for the output cell.
// Assumes: nothing beyond IEEE 1800-2017.
package pal_mc_pkg;

    // Operating style of the cell, decoded from global and local bits
    typedef enum logic [1:0] {
        STYLE_SIMPLE  = 2'd0,
        STYLE_COMPLEX = 2'd1,
        STYLE_REG     = 2'd2,
        STYLE_REGCOMB = 2'd3
    } mc_style_e;

    // Source of the pin drive enable
    typedef enum logic [1:0] {
        OE_ALWAYS = 2'd0,
        OE_NEVER  = 2'd1,
        OE_TERM0  = 2'd2,
        OE_SHARED = 2'd3
    } mc_oe_sel_e;

    // Select lines of the four steering multiplexers
    typedef struct packed {
        logic       sum_all;   // include term 0 in the sum
        logic       out_reg;   // output taken from the flip-flop
        mc_oe_sel_e oe_sel;    // enable source
        logic       fb_reg;    // feedback taken from the flip-flop
    } mc_sel_t;

endpackage

// File: rtl/pal_mc_ctrl.sv
// Module: decodes global and local configuration bits into mux selects.
// Assumes: configuration bits are static while the cell is in use.
module pal_mc_ctrl
    import pal_mc_pkg::*;
(
    input  logic    glb_sync,
    input  logic    glb_tsel,
    input  logic    cell_mode,
    output mc_sel_t sel
);

    mc_style_e style;

    // Pick the operating style from the three configuration bits
    always_comb begin
        if (glb_sync)
            style = cell_mode ? STYLE_REG : STYLE_REGCOMB;
        else
            style = glb_tsel ? STYLE_COMPLEX : STYLE_SIMPLE;
    end

    // Drive the four multiplexer selects for the chosen style
    always_comb begin
        sel = '{sum_all: 1'b0, out_reg: 1'b0, oe_sel: OE_TERM0, fb_reg: 1'b0};
        unique case (style)
            STYLE_SIMPLE: begin
                sel.sum_all = 1'b1;
                sel.oe_sel  = cell_mode ? OE_NEVER : OE_ALWAYS;
            end
            STYLE_REG: begin
                sel.out_reg = 1'b1;
                sel.fb_reg  = 1'b1;
                sel.oe_sel  = OE_SHARED;
            end
            default: begin
                sel.oe_sel  = OE_TERM0;
            end
        endcase
    end

endmodule

// File: rtl/pal_mc_sum.sv
// Module: fixed OR of the product terms, with term 0 optionally masked.
// Assumes: N_TERMS >= 2.
module pal_mc_sum #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] pterm,
    input  logic               sum_all,
    output logic               sum
);

    logic [N_TERMS-1:0] gated;

    // Term 0 may be withheld from the sum; the others always pass
    generate
        for (genvar i = 0; i < N_TERMS; i++) begin : g_term
            if (i == 0) begin : g_first
                assign gated[i] = pterm[i] & sum_all;
            end else begin : g_rest
                assign gated[i] = pterm[i];
            end
        end
    endgenerate

    // Wide OR forming the sum-of-products result
    always_comb sum = |gated;

endmodule

// File: rtl/pal_mc_reg.sv
// Module: output flip-flop with test preload and start-up clear.
// Assumes: rst_n is synchronous active-low; priority is reset, preload, capture.
module pal_mc_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d,
    output logic q
);

    // Store the sum, unless reset or preload overrides it
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (preload_en)
            q <= preload_val;
        else
            q <= d;
    end

endmodule

// File: rtl/pal_macrocell.sv
// Module: top of one configurable output cell.
// Assumes: glb_sync/glb_tsel are shared by all cells; cell_mode and loc_inv are per cell.
module pal_macrocell
    import pal_mc_pkg::*;
#(
    parameter int N_TERMS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] pterm,
    input  logic               glb_sync,
    input  logic               glb_tsel,
    input  logic               cell_mode,
    input  logic               loc_inv,
    input  logic               oe_pin_n,
    input  logic               pad_in,
    input  logic               preload_en,
    input  logic               preload_val,
    output logic               out_data,
    output logic               out_en,
    output logic               fb
);

    mc_sel_t sel;
    logic    sum;
    logic    q;
    logic    pre_pol;

    pal_mc_ctrl u_ctrl (
        .glb_sync  (glb_sync),
        .glb_tsel  (glb_tsel),
        .cell_mode (cell_mode),
        .sel       (sel)
    );

    pal_mc_sum #(.N_TERMS(N_TERMS)) u_sum (
        .pterm   (pterm),
        .sum_all (sel.sum_all),
        .sum     (sum)
    );

    pal_mc_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .d           (sum),
        .q           (q)
    );

    // Output source mux, then polarity
    always_comb begin
        pre_pol  = sel.out_reg ? q : sum;
        out_data = pre_pol ^ loc_inv;
    end

    // Enable source mux
    always_comb begin
        unique case (sel.oe_sel)
            OE_ALWAYS: out_en = 1'b1;
            OE_NEVER:  out_en = 1'b0;
            OE_TERM0:  out_en = pterm[0];
            OE_SHARED: out_en = ~oe_pin_n;
            default:   out_en = 1'b0;
        endcase
    end

    // Feedback mux: stored bit, or the level present on the pin
    always_comb begin
        if (sel.fb_reg)
            fb = q;
        else
            fb = out_en ? out_data : pad_in;
    end

endmodule

// File: rtl/pal_macrocell_chk.sv
// Module: property checker for the output cell, attached by bind.
// Assumes: sees only the top-level ports.
module pal_macrocell_chk #(
    parameter int N_TERMS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TERMS-1:0] pterm,
    input logic               glb_sync,
    input logic               glb_tsel,
    input logic               cell_mode,
    input logic               loc_inv,
    input logic               oe_pin_n,
    input logic               preload_en,
    input logic               preload_val,
    input logic               out_data,
    input logic               out_en,
    input logic               fb
);

    logic is_reg;
    logic simple;
    logic term_oe;

    // Style flags used by the properties
    always_comb begin
        is_reg  = glb_sync & cell_mode;
        simple  = ~glb_sync & ~glb_tsel;
        term_oe = ~is_reg & ~simple;
    end

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_reg && !preload_en) |=> (!is_reg || fb == $past(|pterm[N_TERMS-1:1]))); // R4
    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (!is_reg || fb == $past(preload_val))); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!is_reg || fb == 1'b0)); // R10
    AST_SHARED_OE: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> (out_en == !oe_pin_n)); // R5
    AST_TERM_OE: assert property (@(posedge clk) disable iff (!rst_n)
        term_oe |-> (out_en == pterm[0])); // R3
    AST_SIMPLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        simple |-> (out_en == !cell_mode)); // R2
    AST_REG_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> (out_data == (fb ^ loc_inv))); // R7

endmodule

bind pal_macrocell pal_macrocell_chk #(.N_TERMS(N_TERMS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pterm       (pterm),
    .glb_sync    (glb_sync),
    .glb_tsel    (glb_tsel),
    .cell_mode   (cell_mode),
    .loc_inv     (loc_inv),
    .oe_pin_n    (oe_pin_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .out_data    (out_data),
    .out_en      (out_en),
    .fb          (fb)
);

// File: tb/pal_macrocell_tb_top.sv
`timescale 1ns/1ps
module pal_macrocell_tb_top;

    localparam int N = 8;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pterm = '0;
    logic         glb_sync = 1'b1;
    logic         glb_tsel = 1'b0;
    logic         cell_mode = 1'b1;
    logic         loc_inv = 1'b0;
    logic         oe_pin_n = 1'b0;
    logic         pad_in = 1'b0;
    logic         preload_en = 1'b0;
    logic         preload_val = 1'b0;
    logic         out_data;
    logic         out_en;
    logic         fb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pal_macrocell #(.N_TERMS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .glb_sync(glb_sync),
        .glb_tsel(glb_tsel), .cell_mode(cell_mode), .loc_inv(loc_inv),
        .oe_pin_n(oe_pin_n), .pad_in(pad_in), .preload_en(preload_en),
        .preload_val(preload_val), .out_data(out_data), .out_en(out_en), .fb(fb)
    );

    // {sync, tsel, mode, inv, pterm[7:0], oe_pin_n, pad_in, exp data, exp en, exp fb}
    localparam logic [16:0] VEC [NV] = '{
        {4'b0000, 8'h00, 2'b10, 3'b010},  // R1 simple, zero sum
        {4'b0000, 8'h01, 2'b10, 3'b111},  // R1 simple, term 0 counts
        {4'b0001, 8'h01, 2'b10, 3'b010},  // R7 simple inverted
        {4'b0010, 8'h80, 2'b10, 3'b100},  // R2 released, fb from pad
        {4'b0010, 8'h00, 2'b11, 3'b001},  // R2/R8 released, pad high
        {4'b0100, 8'h01, 2'b10, 3'b010},  // R3 term 0 enables only
        {4'b0100, 8'h03, 2'b10, 3'b111},  // R3 sum of upper terms
        {4'b0101, 8'h02, 2'b11, 3'b001},  // R3/R8 disabled, fb from pad
        {4'b1000, 8'h05, 2'b10, 3'b111},  // R6 registered-family comb
        {4'b1001, 8'h00, 2'b10, 3'b100},  // R6/R7 disabled inverted
        {4'b0100, 8'h01, 2'b00, 3'b010}   // R3 shared pin ignored
    };

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got {data,en,fb}=%b expected %b", tag, got, exp);
        end
    endtask

    // Apply inputs at the falling edge, then sample just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_reg(input logic inv, input logic [N-1:0] pt,
                           input logic pl_en, input logic pl_val);
        @(negedge clk);
        glb_sync = 1'b1; glb_tsel = 1'b0; cell_mode = 1'b1;
        loc_inv = inv; pterm = pt; preload_en = pl_en; preload_val = pl_val;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset beats a preload of 1
        preload_en = 1'b1; preload_val = 1'b1;
        step();
        chk("R10 reset over preload", {out_data, out_en, fb}, 3'b010);
        @(negedge clk);
        rst_n = 1'b1; preload_en = 1'b0;

        // Combinatorial table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {glb_sync, glb_tsel, cell_mode, loc_inv} = VEC[i][16:13];
            pterm = VEC[i][12:5];
            {oe_pin_n, pad_in} = VEC[i][4:3];
            #1;
            chk($sformatf("R1/R2/R3/R6/R8 vector %0d", i), {out_data, out_en, fb}, VEC[i][2:0]);
        end

        // R4: capture of upper terms
        @(negedge clk); oe_pin_n = 1'b0; pad_in = 1'b0;
        set_reg(1'b0, 8'h02, 1'b0, 1'b0);
        #1;
        chk("R4 held before edge", {out_data, out_en, fb}, 3'b010);
        step();
        chk("R4 captured sum", {out_data, out_en, fb}, 3'b111);
        set_reg(1'b0, 8'h01, 1'b0, 1'b0);
        step();
        chk("R4 term 0 excluded", {out_data, out_en, fb}, 3'b010);

        // R7: inverted registered output, fb true
        set_reg(1'b1, 8'h40, 1'b0, 1'b0);
        step();
        chk("R7 registered inverted", {out_data, out_en, fb}, 3'b011);

        // R5: shared pin disables, fb still stored bit (R8)
        @(negedge clk); oe_pin_n = 1'b1;
        #1;
        chk("R5/R8 shared disable", {out_data, out_en, fb}, 3'b001);
        @(negedge clk); oe_pin_n = 1'b0;

        // R9: preload loads a value, and beats a conflicting capture
        set_reg(1'b0, 8'h00, 1'b1, 1'b1);
        step();
        chk("R9 preload one", {out_data, out_en, fb}, 3'b111);
        set_reg(1'b0, 8'h80, 1'b1, 1'b0);
        step();
        chk("R9 preload over capture", {out_data, out_en, fb}, 3'b010);

        // R10: mid-run reset clears a stored one despite preload
        set_reg(1'b0, 8'h80, 1'b0, 1'b0);
        step();
        chk("R4 set before reset", {out_data, out_en, fb}, 3'b111);
        @(negedge clk); rst_n = 1'b0; preload_en = 1'b1; preload_val = 1'b1;
        step();
        chk("R10 mid-run reset", {out_data, out_en, fb}, 3'b010);
        @(negedge clk); rst_n = 1'b1; preload_en = 1'b0;

        finish_run();
    end

endmodule